// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Unit

This block sits beside a BCD calendar counter and watches it for two programmable
alarm conditions. Each time the counter signals its once-per-second update, the
block compares the freshly updated time fields with the contents of two alarm
register sets. Every alarm field carries a mask bit that removes it from the
comparison, so one register set can request an event every second, every minute,
every hour, every day or on one specific date. The day field of each alarm can be
compared against either the day of the week or the date of the month.

A match sets a sticky flag that software can only clear. The flags are routed to
two active-low pins under control of a routing bit. With routing set, each alarm
owns one pin. With routing clear, both alarms share the first pin and the second
pin carries a square wave. The square wave is divided from a 32.768 kHz oscillator
level input to one of four selectable rates, and it can be frozen high with an
oscillator-off bit. Host writes arrive on a simple single-cycle write port.

Top module: `tod_alarm_unit`

## Requirements
- R1: After reset both flags read 0, both interrupt enables are 0, routing is 0, the rate field is 11 and the oscillator-off bit is 0. So `irq_a_n` is 1 and `irq_b_n` follows the oscillator level, changing every time it changes.
- R2: The alarm comparison takes effect only in a cycle where `sec_tick` is 1. A flag set by that comparison is visible on `alarm_flags` one clock later. Time fields that match while `sec_tick` is 0 set nothing.
- R3: Alarm 1 occupies addresses 0 (seconds), 1 (minutes), 2 (hours) and 3 (day/date). In each alarm register, bit 7 is a mask bit, and a value of 1 excludes that field. An unmasked field matches when its bits 6:0, with a 0 above them, equal the 8-bit time input. With all four masks set, every `sec_tick` sets the flag.
- R4: Alarm 2 occupies addresses 4 (minutes), 5 (hours) and 6 (day/date) and has no seconds register. It matches only when `tm_sec` is 8'h00 and every unmasked field matches, so with all masks set it fires once per minute.
- R5: In a day/date register, bit 6 selects the source for the comparison of bits 5:0. A 1 compares them with `tm_wday` and a 0 compares them with `tm_mday`.
- R6: Address 8 is the status register, with bit 0 for alarm 1 and bit 1 for alarm 2. Writing 0 to a bit clears that flag and writing 1 leaves it unchanged. Otherwise a flag stays set. A match in the same cycle as a clear write leaves the flag set.
- R7: Address 7 is the control register. Its bits are 0 = enable 1, 1 = enable 2, 2 = routing, 4:3 = rate and 7 = oscillator off. With routing 1, `irq_a_n` is low exactly when flag 1 AND enable 1 hold, and `irq_b_n` is low exactly when flag 2 AND enable 2 hold. Both pins are registered and change one clock after the flag or control register that drives them.
- R8: With routing 0, `irq_a_n` is low when (flag 1 AND enable 1) OR (flag 2 AND enable 2) holds, and `irq_b_n` carries the square wave.
- R9: The square-wave half period depends on the rate field. It is 16384 oscillator rising edges for 00 (1 Hz), 4 edges for 01 (4.096 kHz) and 2 edges for 10 (8.192 kHz). For 11 (32.768 kHz) the wave follows the oscillator level.
- R10: With the oscillator-off bit at 1, the divider holds its count and the square wave stays at 1.
- R11: Writes to addresses 9 to 15 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_lvl | input | 1 | 32.768 kHz oscillator level, already synchronous to clk |
| sec_tick | input | 1 | One-cycle once-per-second calendar update strobe |
| tm_sec | input | 8 | Current BCD seconds |
| tm_min | input | 8 | Current BCD minutes |
| tm_hour | input | 8 | Current hours, including the 12/24 and AM/PM bits |
| tm_wday | input | 8 | Current day of week |
| tm_mday | input | 8 | Current BCD date of month |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 4 | Host register address |
| reg_wdata | input | 8 | Host register write data |
| alarm_flags | output | 2 | Sticky flags; bit 0 alarm 1, bit 1 alarm 2 |
| irq_a_n | output | 1 | Active-low interrupt pin A |
| irq_b_n | output | 1 | Active-low interrupt B or square-wave pin |

## Verification
A corrupted alarm field, mask bit or day/date select shows up on `alarm_flags` one clock after the next `sec_tick` whose time fields expose the difference. Sweeping random masks and field values over small pools of matching and non-matching times makes that exposure frequent. A wrong flag or control bit reaches the pins one clock after that. A divider fault shows up as a wrong interval between square-wave transitions, and these intervals are measured directly in clock cycles for every rate.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;

  localparam int N_ALARM = 2;
  localparam int N_FIELD = 4;

  // field slots inside one alarm set
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;

  // register addresses
  localparam int ADR_CTRL = 7;
  localparam int ADR_STAT = 8;

  // bit positions inside alarm registers
  localparam int MASK_BIT = 7;
  localparam int DYDT_BIT = 6;

  // bit positions inside the control register
  localparam int CB_IE1     = 0;
  localparam int CB_IE2     = 1;
  localparam int CB_ROUTE   = 2;
  localparam int CB_RATE    = 3;
  localparam int CB_OSC_OFF = 7;

  typedef enum logic [1:0] {
    RATE_1HZ  = 2'b00,
    RATE_4K   = 2'b01,
    RATE_8K   = 2'b10,
    RATE_32K  = 2'b11
  } sqw_rate_e;

  typedef struct packed {
    logic      osc_off;
    sqw_rate_e rate;
    logic      route;
    logic      ie2;
    logic      ie1;
  } ctrl_t;

  // register address of alarm g, field f; -1 when the slot has no register
  function automatic int slot_addr(input int g, input int f);
    if (g == 0) return f;
    if (f == F_SEC) return -1;
    return 3 + f;
  endfunction

endpackage

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_alarm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [N_FIELD-1:0][DW-1:0] alm,
  input  logic [DW-1:0]              tm_sec,
  input  logic [DW-1:0]              tm_min,
  input  logic [DW-1:0]              tm_hour,
  input  logic [DW-1:0]              tm_wday,
  input  logic [DW-1:0]              tm_mday,
  output logic                       hit
);

  localparam int VAL_W = MASK_BIT;   // value bits below the mask bit
  localparam int DAY_W = DYDT_BIT;   // day/date value bits below the select bit

  logic [N_FIELD-1:0][DW-1:0] cur;
  logic [N_FIELD-1:0]         fld_ok;

  always_comb begin
    cur[F_SEC]  = tm_sec;
    cur[F_MIN]  = tm_min;
    cur[F_HOUR] = tm_hour;
    cur[F_DAY]  = alm[F_DAY][DYDT_BIT] ? tm_wday : tm_mday;
  end

  for (genvar f = 0; f < N_FIELD; f++) begin : g_fld
    if (f == F_DAY) begin : g_day
      assign fld_ok[f] = alm[f][MASK_BIT] ||
                         ({{(DW-DAY_W){1'b0}}, alm[f][DAY_W-1:0]} == cur[f]);
    end else begin : g_time
      assign fld_ok[f] = alm[f][MASK_BIT] ||
                         ({{(DW-VAL_W){1'b0}}, alm[f][VAL_W-1:0]} == cur[f]);
    end
  end

  assign hit = &fld_ok;

endmodule

// File: rtl/tod_sqw_gen.sv
module tod_sqw_gen
  import tod_alarm_pkg::*;
#(
  parameter int OSC_HZ = 32768,
  parameter int F_FAST = 8192,
  parameter int F_SLOW = 4096
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      osc_lvl,
  input  logic      osc_off,
  input  sqw_rate_e rate,
  output logic      wave
);

  localparam int DIV_W  = $clog2(OSC_HZ);
  localparam int B_1HZ  = DIV_W - 1;
  localparam int B_FAST = $clog2(OSC_HZ / F_FAST) - 1;
  localparam int B_SLOW = $clog2(OSC_HZ / F_SLOW) - 1;

  logic             osc_q;
  logic [DIV_W-1:0] cnt_q;
  logic             rise;
  logic             sel;

  assign rise = osc_lvl && !osc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      osc_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      osc_q <= osc_lvl;
      if (rise && !osc_off) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    unique case (rate)
      RATE_1HZ: sel = cnt_q[B_1HZ];
      RATE_4K:  sel = cnt_q[B_SLOW];
      RATE_8K:  sel = cnt_q[B_FAST];
      default:  sel = osc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) wave <= 1'b1;
    else     wave <= osc_off ? 1'b1 : sel;
  end

endmodule

// File: rtl/tod_irq_route.sv
module tod_irq_route
  import tod_alarm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [N_ALARM-1:0] flags,
  input  logic [N_ALARM-1:0] ie,
  input  logic               route,
  input  logic               wave,
  output logic               irq_a_n,
  output logic               irq_b_n
);

  logic [N_ALARM-1:0] act;
  assign act = flags & ie;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_a_n <= 1'b1;
      irq_b_n <= 1'b1;
    end else if (route) begin
      irq_a_n <= !act[0];
      irq_b_n <= !act[1];
    end else begin
      irq_a_n <= !(|act);
      irq_b_n <= wave;
    end
  end

endmodule

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit
  import tod_alarm_pkg::*;
#(
  parameter int OSC_HZ = 32768,
  parameter int AW     = 4,
  parameter int DW     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          osc_lvl,
  input  logic          sec_tick,
  input  logic [DW-1:0] tm_sec,
  input  logic [DW-1:0] tm_min,
  input  logic [DW-1:0] tm_hour,
  input  logic [DW-1:0] tm_wday,
  input  logic [DW-1:0] tm_mday,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [1:0]    alarm_flags,
  output logic          irq_a_n,
  output logic          irq_b_n
);

  localparam ctrl_t CTRL_RST = '{osc_off: 1'b0, rate: RATE_32K,
                                 route: 1'b0, ie2: 1'b0, ie1: 1'b0};

  logic [N_ALARM-1:0][N_FIELD-1:0][DW-1:0] alm_vec;
  logic [N_ALARM-1:0]                      hit;
  logic [N_ALARM-1:0]                      flag_q;
  ctrl_t                                   ctrl_q;
  logic                                    sqw_wave;
  logic                                    wr_ctrl;
  logic                                    wr_stat;

  assign wr_ctrl = reg_we && (reg_addr == AW'(ADR_CTRL));
  assign wr_stat = reg_we && (reg_addr == AW'(ADR_STAT));

  // alarm register sets and their comparators
  for (genvar g = 0; g < N_ALARM; g++) begin : g_alm
    for (genvar f = 0; f < N_FIELD; f++) begin : g_fld
      localparam int SA = slot_addr(g, f);
      if (SA < 0) begin : g_fixed
        assign alm_vec[g][f] = '0;   // unmasked, compares against zero
      end else begin : g_reg
        logic [DW-1:0] r_q;
        always_ff @(posedge clk) begin
          if (rst)                                    r_q <= '0;
          else if (reg_we && reg_addr == AW'(SA))     r_q <= reg_wdata;
        end
        assign alm_vec[g][f] = r_q;
      end
    end

    tod_alarm_match #(.DW(DW)) u_match (
      .alm     (alm_vec[g]),
      .tm_sec  (tm_sec),
      .tm_min  (tm_min),
      .tm_hour (tm_hour),
      .tm_wday (tm_wday),
      .tm_mday (tm_mday),
      .hit     (hit[g])
    );
  end

  // control register
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
    end else if (wr_ctrl) begin
      ctrl_q.osc_off <= reg_wdata[CB_OSC_OFF];
      ctrl_q.rate    <= sqw_rate_e'(reg_wdata[CB_RATE+1:CB_RATE]);
      ctrl_q.route   <= reg_wdata[CB_ROUTE];
      ctrl_q.ie2     <= reg_wdata[CB_IE2];
      ctrl_q.ie1     <= reg_wdata[CB_IE1];
    end
  end

  // sticky flags: a match wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
    end else begin
      for (int g = 0; g < N_ALARM; g++) begin
        if (sec_tick && hit[g])            flag_q[g] <= 1'b1;
        else if (wr_stat && !reg_wdata[g]) flag_q[g] <= 1'b0;
      end
    end
  end

  assign alarm_flags = flag_q;

  tod_sqw_gen #(.OSC_HZ(OSC_HZ)) u_sqw (
    .clk     (clk),
    .rst     (rst),
    .osc_lvl (osc_lvl),
    .osc_off (ctrl_q.osc_off),
    .rate    (ctrl_q.rate),
    .wave    (sqw_wave)
  );

  tod_irq_route u_route (
    .clk     (clk),
    .rst     (rst),
    .flags   (flag_q),
    .ie      ({ctrl_q.ie2, ctrl_q.ie1}),
    .route   (ctrl_q.route),
    .wave    (sqw_wave),
    .irq_a_n (irq_a_n),
    .irq_b_n (irq_b_n)
  );

endmodule

// File: rtl/tod_alarm_unit_chk.sv
module tod_alarm_unit_chk
  import tod_alarm_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          sec_tick,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [1:0]    alarm_flags,
  input logic          irq_a_n,
  input logic          irq_b_n,
  input ctrl_t         ctrl,
  input logic          wave
);

  // R2: a flag only rises right after an update strobe
  a_r2_f1_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_flags[0]) |-> $past(sec_tick));
  a_r2_f2_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_flags[1]) |-> $past(sec_tick));

  // R6: a flag only falls after a zero is written to its status bit
  a_r6_f1_clear_only: assert property (@(posedge clk) disable iff (rst)
    $fell(alarm_flags[0]) |->
      $past(reg_we && reg_addr == AW'(ADR_STAT) && !reg_wdata[0]));
  a_r6_f2_clear_only: assert property (@(posedge clk) disable iff (rst)
    $fell(alarm_flags[1]) |->
      $past(reg_we && reg_addr == AW'(ADR_STAT) && !reg_wdata[1]));

  // R7: with no flag set, pin A is released on the next clock
  a_r7_a_idle: assert property (@(posedge clk) disable iff (rst)
    (alarm_flags == 2'b00) |=> irq_a_n);

  // R7: with separate routing and no alarm 2 flag, pin B is released
  a_r7_b_idle: assert property (@(posedge clk) disable iff (rst)
    (ctrl.route && !alarm_flags[1]) |=> irq_b_n);

  // R10: with the oscillator off the wave is held high
  a_r10_wave_high: assert property (@(posedge clk) disable iff (rst)
    ctrl.osc_off |=> wave);

endmodule

bind tod_alarm_unit tod_alarm_unit_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sec_tick    (sec_tick),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .alarm_flags (alarm_flags),
  .irq_a_n     (irq_a_n),
  .irq_b_n     (irq_b_n),
  .ctrl        (ctrl_q),
  .wave        (sqw_wave)
);

// File: tb/tod_alarm_unit_test.sv
`timescale 1ns/1ps
module tod_alarm_unit_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_lvl = 1'b0;
  logic       sec_tick = 1'b0;
  logic [7:0] tm_sec = 8'h00, tm_min = 8'h00, tm_hour = 8'h00;
  logic [7:0] tm_wday = 8'h01, tm_mday = 8'h01;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic [7:0] reg_wdata = 8'h00;
  logic [1:0] alarm_flags;
  logic       irq_a_n, irq_b_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench shadow of the alarm registers and flags
  logic [7:0] m_alm [2][4];
  logic [1:0] exp_f = 2'b00;

  always #2.5 clk = ~clk;
  always @(negedge clk) osc_lvl <= ~osc_lvl;

  tod_alarm_unit uut (
    .clk(clk), .rst(rst), .osc_lvl(osc_lvl), .sec_tick(sec_tick),
    .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour),
    .tm_wday(tm_wday), .tm_mday(tm_mday),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .alarm_flags(alarm_flags), .irq_a_n(irq_a_n), .irq_b_n(irq_b_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit fld_eq(input logic [7:0] a, input logic [7:0] t);
    return a[7] || ({1'b0, a[6:0]} == t);
  endfunction

  function automatic bit calc_hit(input int g);
    logic [7:0] d;
    logic [7:0] src;
    bit ok;
    d   = m_alm[g][3];
    src = d[6] ? tm_wday : tm_mday;
    ok  = d[7] || ({2'b00, d[5:0]} == src);
    ok  = ok && fld_eq(m_alm[g][1], tm_min) && fld_eq(m_alm[g][2], tm_hour);
    if (g == 0) ok = ok && fld_eq(m_alm[0][0], tm_sec);
    else        ok = ok && (tm_sec == 8'h00);
    return ok;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a <= 4'd3)       m_alm[0][a] = d;
    else if (a <= 4'd6)  m_alm[1][a-3] = d;
    else if (a == 4'd8)  exp_f = exp_f & d[1:0];
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    exp_f = exp_f | {calc_hit(1), calc_hit(0)};
  endtask

  task automatic set_time(input logic [7:0] s, m, h, w, d);
    tm_sec = s; tm_min = m; tm_hour = h; tm_wday = w; tm_mday = d;
  endtask

  // waits out two transitions, then counts cycles to the next one
  task automatic half_period(output int n);
    logic p;
    @(negedge clk);
    p = irq_b_n;
    for (int k = 0; k < 2; k++) begin
      int c = 0;
      while (irq_b_n == p && c < 70000) begin @(negedge clk); c++; end
      p = irq_b_n;
    end
    n = 0;
    while (irq_b_n == p && n < 70000) begin @(negedge clk); n++; end
  endtask

  function automatic logic [7:0] pick(input int f);
    logic [7:0] v;
    bit s = $urandom_range(0, 1);
    case (f)
      0: v = s ? 8'h15 : 8'h00;
      1: v = s ? 8'h30 : 8'h00;
      2: v = s ? 8'h52 : 8'h08;
      default: v = s ? 8'h02 : 8'h01;
    endcase
    return v;
  endfunction

  initial begin
    #(5.0 * 180000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int hp;
    void'($urandom(32'hC0FFEE));
    for (int g = 0; g < 2; g++) for (int f = 0; f < 4; f++) m_alm[g][f] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(alarm_flags == 2'b00, "R1 flags after reset", alarm_flags, 0);
    chk(irq_a_n == 1'b1, "R1 irq_a_n after reset", irq_a_n, 1);
    half_period(hp);
    chk(hp == 1, "R1 R9 32k wave after reset", hp, 1);

    // R2 / R3: every-second alarm 1, alarm 2 needs zero seconds (R4)
    set_time(8'h15, 8'h30, 8'h08, 8'h02, 8'h02);
    wr(4'd0, 8'h80); wr(4'd1, 8'h80); wr(4'd2, 8'h80); wr(4'd3, 8'h80);
    wr(4'd4, 8'h80); wr(4'd5, 8'h80); wr(4'd6, 8'h80);
    repeat (5) @(negedge clk);
    chk(alarm_flags == 2'b00, "R2 no flag without tick", alarm_flags, 0);
    tick();
    chk(alarm_flags == 2'b01, "R3 all-masked alarm 1 fires", alarm_flags, 1);
    set_time(8'h00, 8'h31, 8'h08, 8'h02, 8'h02);
    tick();
    chk(alarm_flags == 2'b11, "R4 alarm 2 at zero seconds", alarm_flags, 3);

    // R6 clear semantics
    wr(4'd8, 8'hFF);
    chk(alarm_flags == 2'b11, "R6 write ones keeps flags", alarm_flags, 3);
    wr(4'd8, 8'hFE);
    chk(alarm_flags == 2'b10, "R6 write zero clears flag 1", alarm_flags, 2);
    set_time(8'h15, 8'h31, 8'h08, 8'h02, 8'h02);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'd8; reg_wdata = 8'h00; sec_tick = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; sec_tick = 1'b0;
    exp_f = 2'b01;
    chk(alarm_flags == 2'b01, "R6 match beats clear", alarm_flags, 1);

    // R11 unmapped addresses
    for (int a = 9; a < 16; a++) wr(4'(a), 8'h00);
    chk(alarm_flags == 2'b01, "R11 unmapped writes ignored", alarm_flags, 1);

    // R5 day/date selection
    wr(4'd8, 8'h00);
    set_time(8'h15, 8'h31, 8'h08, 8'h03, 8'h05);
    wr(4'd3, 8'h43); tick();
    chk(alarm_flags[0] == 1'b1, "R5 weekday match", alarm_flags, 1);
    wr(4'd8, 8'h00); wr(4'd3, 8'h03); tick();
    chk(alarm_flags[0] == 1'b0, "R5 date compare ignores weekday", alarm_flags, 0);
    wr(4'd3, 8'h05); tick();
    chk(alarm_flags[0] == 1'b1, "R5 date match", alarm_flags, 1);

    // R7 separate routing
    wr(4'd3, 8'h80);
    wr(4'd7, 8'h1F);
    @(negedge clk);
    chk(irq_a_n == 1'b0, "R7 pin A from alarm 1", irq_a_n, 0);
    chk(irq_b_n == 1'b1, "R7 pin B idle", irq_b_n, 1);
    set_time(8'h00, 8'h31, 8'h08, 8'h03, 8'h05);
    tick();
    @(negedge clk);
    chk(irq_b_n == 1'b0, "R7 pin B from alarm 2", irq_b_n, 0);
    wr(4'd7, 8'h1E);
    @(negedge clk);
    chk(irq_a_n == 1'b1, "R7 enable 1 off releases A", irq_a_n, 1);
    chk(irq_b_n == 1'b0, "R7 pin B still low", irq_b_n, 0);

    // R8 shared routing
    wr(4'd7, 8'h1A);
    @(negedge clk);
    chk(irq_a_n == 1'b0, "R8 alarm 2 on pin A", irq_a_n, 0);
    half_period(hp);
    chk(hp == 1, "R8 pin B carries wave", hp, 1);
    wr(4'd7, 8'h18);
    @(negedge clk);
    chk(irq_a_n == 1'b1, "R8 no enables releases A", irq_a_n, 1);

    // R9 rates
    wr(4'd7, 8'h10); half_period(hp);
    chk(hp == 4, "R9 8k half period", hp, 4);
    wr(4'd7, 8'h08); half_period(hp);
    chk(hp == 8, "R9 4k half period", hp, 8);

    // R10 oscillator off
    wr(4'd7, 8'h98);
    repeat (3) @(negedge clk);
    begin
      bit all_high = 1'b1;
      for (int k = 0; k < 50; k++) begin
        @(negedge clk);
        if (!irq_b_n) all_high = 1'b0;
      end
      chk(all_high, "R10 wave held high", all_high, 1);
    end

    wr(4'd7, 8'h00); half_period(hp);
    chk(hp == 32768, "R9 1Hz half period", hp, 32768);

    // random sweep of masks, day/date select and times (R3 R4 R5 R6)
    wr(4'd8, 8'h00);
    for (int it = 0; it < 300; it++) begin
      for (int f = 0; f < 4; f++) begin
        logic [7:0] v = pick(f);
        if ($urandom_range(0, 1)) v[7] = 1'b1;
        if (f == 3 && $urandom_range(0, 1)) v[6] = 1'b1;
        wr(4'(f), v);
        if (f > 0) wr(4'(f + 3), v);
      end
      if ($urandom_range(0, 2) == 0) wr(4'd8, 8'($urandom_range(0, 3)));
      set_time(pick(0), pick(1), pick(2), pick(3), pick(3));
      if ($urandom_range(0, 3) == 0) tm_sec = 8'h00;
      tick();
      chk(alarm_flags == exp_f, "R3 R4 R5 R6 random compare", alarm_flags, exp_f);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule